// File: doc/BRIEF.md
# Wait-State Paced Write Controller

This block sits on a 16-bit processor core bus and completes write transfers toward two kinds of target. The first kind is chip-selected static devices such as boot memory, peripherals and registers. The second is DRAM. When the core drops its address strobe for a write with a memory-space function code, the block matches the address against a small set of base/mask windows and selects one target. It then paces the access using that target's wait-state count, which arrives on input ports, and never lets an access last fewer than four clocks.

For a chip-selected device the block pulls that device's select low and passes the upper and lower data strobes through to the two byte write enables. For DRAM it presents the row half of the address together with RAS. One clock later it switches the same 11-bit bus to the column half and asserts CAS and the DRAM write enable. The two DRAM byte selects follow the data strobes. An address that falls in no window is still acknowledged, after a fixed default count, so the core cannot hang.

The acknowledge stays low until the core releases the address strobe. On that edge every strobe goes inactive. A stall output stays high for the whole access, so an external master can be held off during it.

Top module: `wr_pace_ctrl`

## Requirements
- R1: While `rst` is high, and on the first clock after it, every active-low output (`cs_n`, `wru_n`, `wrl_n`, `ras_n`, `cas_n`, `dwe_n`, `dcs_n`, `dtack_n`) is high, `ma` is zero and `stall` is low.
- R2: An access starts on a rising edge at which the block is idle and samples `as_n`=0, `rw_n`=0 and `fc`≠3'b111. It also needs `as_n` to have been sampled high on some edge since reset or since the previous start. Reads (`rw_n`=1) and `fc`=3'b111 start nothing.
- R3: With default parameters the address decodes to exactly one target. `addr[23:20]`=0 selects region 0 and `addr[23:20]`=1 selects region 1. `addr[23:16]`=8'h20 selects region 2 and 8'h21 selects region 3. `addr[23]`=1 selects DRAM. Anything else is unmapped. If windows overlap, the lowest region index wins over higher ones and over DRAM.
- R4: For chip-select region i, `cs_n[i]` is low from the clock after the start edge until the access ends. During that time `wru_n` equals the `uds_n` sampled at start and `wrl_n` equals the sampled `lds_n`. A word write has both strobes low. A byte write has `uds_n` low for even addresses (`addr[0]`=0) and `lds_n` low for odd ones.
- R5: For DRAM, `ras_n` is low and `ma`=`addr[22:12]` (row) from the clock after start. From one clock later, `ma`=`addr[11:1]` (column) and `cas_n` and `dwe_n` are low. `dcs_n[1]` follows the sampled `uds_n` and `dcs_n[0]` follows the sampled `lds_n`.
- R6: With start at edge 0, `dtack_n` goes low after edge L−1, where L = max(4, ws+2). Here ws is the 4-bit wait count of the selected target, taken from `ws_cs[4i+3:4i]` or from `ws_dram`.
- R7: An unmapped address drives no select, write enable or DRAM strobe, yet is acknowledged with ws equal to the default count of 6 (L=8).
- R8: The acknowledge and all strobes hold while `as_n` stays low. On the edge that samples `as_n` high they all return to their inactive levels.
- R9: `stall` is high from the clock after the start edge until the access ends.
- R10: If `as_n` is sampled high before the acknowledge, the access is abandoned on that edge and `dtack_n` never goes low for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| as_n | input | 1 | Core address strobe, active low |
| rw_n | input | 1 | High for read, low for write |
| uds_n | input | 1 | Upper data strobe, active low |
| lds_n | input | 1 | Lower data strobe, active low |
| fc | input | 3 | Core function code; 3'b111 is not a memory access |
| addr | input | ADDR_W (24) | Byte address, bit 0 included |
| ws_cs | input | NREG*WS_W (16) | Wait counts of the chip-select regions, region i at bits 4i+3:4i |
| ws_dram | input | WS_W (4) | Wait count of the DRAM target |
| cs_n | output | NREG (4) | Region chip-selects, active low |
| wru_n | output | 1 | Upper byte write enable, active low |
| wrl_n | output | 1 | Lower byte write enable, active low |
| ma | output | MA_W (11) | Multiplexed DRAM row/column address |
| ras_n | output | 1 | DRAM row strobe, active low |
| cas_n | output | 1 | DRAM column strobe, active low |
| dwe_n | output | 1 | DRAM write enable, active low |
| dcs_n | output | 2 | DRAM byte selects, bit 1 upper, bit 0 lower |
| dtack_n | output | 1 | Acknowledge to the core, active low |
| stall | output | 1 | High while an access is in progress |

## Verification
All outputs are registered state decoded without a path from the inputs. Each result therefore appears one clock after the rising edge that causes it: the selects, RAS, the row address and `stall` after the start edge, the column address with CAS and write enable one edge later, the acknowledge after edge L−1, and full release after the edge that sees `as_n` high. The reference model steps on the same rising edge as the design and computes what each output must hold for the coming clock. Both are compared at the falling edge in the middle of that clock, so no comparison lands on an edge where a value is changing. Scenarios cover the shortest and the longest access lengths, both byte lanes, the unmapped default, a strobe held past the acknowledge, an abandoned access, and a start refused until the strobe has been seen high.

// File: rtl/wr_pace_pkg.sv
package wr_pace_pkg;

    localparam int IDX_W = 4;

    localparam logic [2:0] FC_CPU_SPACE = 3'b111;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_CS   = 2'd1,
        TGT_DRAM = 2'd2
    } tgt_kind_e;

    typedef struct packed {
        tgt_kind_e        kind;
        logic [IDX_W-1:0] idx;
    } tgt_sel_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_XFER = 2'd1,
        PH_HOLD = 2'd2
    } phase_e;

    typedef struct packed {
        logic up_n;
        logic lo_n;
    } lane_t;

endpackage

// File: rtl/wr_pace_decode.sv
module wr_pace_decode
    import wr_pace_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int NREG   = 4,
    parameter int WS_W   = 4,
    parameter int DEF_WS = 6,
    parameter logic [NREG-1:0][ADDR_W-1:0] CS_BASE = '0,
    parameter logic [NREG-1:0][ADDR_W-1:0] CS_MASK = '0,
    parameter logic [ADDR_W-1:0] DRAM_BASE = '0,
    parameter logic [ADDR_W-1:0] DRAM_MASK = '0
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic [NREG*WS_W-1:0] ws_cs,
    input  logic [WS_W-1:0]      ws_dram,
    output tgt_sel_t             sel,
    output logic [WS_W-1:0]      ws
);

    logic [NREG-1:0] hit;
    logic            dram_hit;

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_win
            assign hit[g] = ((addr & CS_MASK[g]) == CS_BASE[g]);
        end
    endgenerate

    assign dram_hit = ((addr & DRAM_MASK) == DRAM_BASE);

    always_comb begin
        sel = '{kind: TGT_NONE, idx: '0};
        ws  = WS_W'(DEF_WS);
        if (dram_hit) begin
            sel.kind = TGT_DRAM;
            ws       = ws_dram;
        end
        // walk downward so the lowest matching index is applied last
        for (int i = NREG - 1; i >= 0; i--) begin
            if (hit[i]) begin
                sel.kind = TGT_CS;
                sel.idx  = IDX_W'(i);
                ws       = ws_cs[i*WS_W +: WS_W];
            end
        end
    end

endmodule

// File: rtl/wr_pace_seq.sv
module wr_pace_seq
    import wr_pace_pkg::*;
#(
    parameter int WS_W    = 4,
    parameter int MIN_LEN = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            as_n,
    input  logic            rw_n,
    input  logic [2:0]      fc,
    input  logic [WS_W-1:0] ws,
    output logic            start,
    output phase_e          ph,
    output logic            col_ph
);

    localparam int LEN_W = WS_W + 2;

    logic             armed;
    logic [LEN_W-1:0] cnt;
    logic [LEN_W-1:0] last;
    logic [LEN_W-1:0] need;
    logic [LEN_W-1:0] len;
    logic             req;

    assign req   = ~as_n & ~rw_n & (fc != FC_CPU_SPACE) & armed;
    assign start = (ph == PH_IDLE) && req;

    always_comb begin
        need = LEN_W'(ws) + LEN_W'(2);
        len  = (need > LEN_W'(MIN_LEN)) ? need : LEN_W'(MIN_LEN);
    end

    assign col_ph = ((ph == PH_XFER) && (cnt != '0)) || (ph == PH_HOLD);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph    <= PH_IDLE;
            cnt   <= '0;
            last  <= '0;
            armed <= 1'b0;
        end else begin
            if (as_n) begin
                armed <= 1'b1;
            end else if (start) begin
                armed <= 1'b0;
            end
            case (ph)
                PH_IDLE: begin
                    if (start) begin
                        ph   <= PH_XFER;
                        cnt  <= '0;
                        last <= len - LEN_W'(1);
                    end
                end
                PH_XFER: begin
                    if (as_n) begin
                        ph <= PH_IDLE;
                    end else if (LEN_W'(cnt + 1'b1) == last) begin
                        ph <= PH_HOLD;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (as_n) begin
                        ph <= PH_IDLE;
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/wr_pace_drive.sv
module wr_pace_drive
    import wr_pace_pkg::*;
#(
    parameter int NREG = 4,
    parameter int MA_W = 11
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  tgt_sel_t        sel,
    input  lane_t           lane,
    input  logic [MA_W-1:0] row,
    input  logic [MA_W-1:0] col,
    input  phase_e          ph,
    input  logic            col_ph,
    output logic [NREG-1:0] cs_n,
    output logic            wru_n,
    output logic            wrl_n,
    output logic [MA_W-1:0] ma,
    output logic            ras_n,
    output logic            cas_n,
    output logic            dwe_n,
    output logic [1:0]      dcs_n,
    output logic            dtack_n,
    output logic            stall
);

    tgt_sel_t        sel_q;
    lane_t           lane_q;
    logic [MA_W-1:0] row_q;
    logic [MA_W-1:0] col_q;
    logic            busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= '{kind: TGT_NONE, idx: '0};
            lane_q <= '{up_n: 1'b1, lo_n: 1'b1};
            row_q  <= '0;
            col_q  <= '0;
        end else if (start) begin
            sel_q  <= sel;
            lane_q <= lane;
            row_q  <= row;
            col_q  <= col;
        end
    end

    assign busy    = (ph != PH_IDLE);
    assign stall   = busy;
    assign dtack_n = (ph != PH_HOLD);

    always_comb begin
        cs_n  = '1;
        wru_n = 1'b1;
        wrl_n = 1'b1;
        ma    = '0;
        ras_n = 1'b1;
        cas_n = 1'b1;
        dwe_n = 1'b1;
        dcs_n = 2'b11;
        if (busy) begin
            case (sel_q.kind)
                TGT_CS: begin
                    for (int i = 0; i < NREG; i++) begin
                        if (sel_q.idx == IDX_W'(i)) begin
                            cs_n[i] = 1'b0;
                        end
                    end
                    wru_n = lane_q.up_n;
                    wrl_n = lane_q.lo_n;
                end
                TGT_DRAM: begin
                    ras_n = 1'b0;
                    ma    = col_ph ? col_q : row_q;
                    cas_n = ~col_ph;
                    dwe_n = ~col_ph;
                    dcs_n = {lane_q.up_n, lane_q.lo_n};
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/wr_pace_ctrl.sv
module wr_pace_ctrl
    import wr_pace_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int NREG    = 4,
    parameter int WS_W    = 4,
    parameter int MA_W    = 11,
    parameter int MIN_LEN = 4,
    parameter int DEF_WS  = 6,
    parameter logic [NREG-1:0][ADDR_W-1:0] CS_BASE =
        {24'h210000, 24'h200000, 24'h100000, 24'h000000},
    parameter logic [NREG-1:0][ADDR_W-1:0] CS_MASK =
        {24'hFF0000, 24'hFF0000, 24'hF00000, 24'hF00000},
    parameter logic [ADDR_W-1:0] DRAM_BASE = 24'h800000,
    parameter logic [ADDR_W-1:0] DRAM_MASK = 24'h800000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 as_n,
    input  logic                 rw_n,
    input  logic                 uds_n,
    input  logic                 lds_n,
    input  logic [2:0]           fc,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [NREG*WS_W-1:0] ws_cs,
    input  logic [WS_W-1:0]      ws_dram,
    output logic [NREG-1:0]      cs_n,
    output logic                 wru_n,
    output logic                 wrl_n,
    output logic [MA_W-1:0]      ma,
    output logic                 ras_n,
    output logic                 cas_n,
    output logic                 dwe_n,
    output logic [1:0]           dcs_n,
    output logic                 dtack_n,
    output logic                 stall
);

    localparam int COL_LO = 1;
    localparam int ROW_LO = COL_LO + MA_W;

    tgt_sel_t        sel;
    logic [WS_W-1:0] ws;
    logic            start;
    phase_e          ph;
    logic            col_ph;
    lane_t           lane;

    assign lane = '{up_n: uds_n, lo_n: lds_n};

    wr_pace_decode #(
        .ADDR_W   (ADDR_W),
        .NREG     (NREG),
        .WS_W     (WS_W),
        .DEF_WS   (DEF_WS),
        .CS_BASE  (CS_BASE),
        .CS_MASK  (CS_MASK),
        .DRAM_BASE(DRAM_BASE),
        .DRAM_MASK(DRAM_MASK)
    ) u_dec (
        .addr   (addr),
        .ws_cs  (ws_cs),
        .ws_dram(ws_dram),
        .sel    (sel),
        .ws     (ws)
    );

    wr_pace_seq #(
        .WS_W   (WS_W),
        .MIN_LEN(MIN_LEN)
    ) u_seq (
        .clk   (clk),
        .rst   (rst),
        .as_n  (as_n),
        .rw_n  (rw_n),
        .fc    (fc),
        .ws    (ws),
        .start (start),
        .ph    (ph),
        .col_ph(col_ph)
    );

    wr_pace_drive #(
        .NREG(NREG),
        .MA_W(MA_W)
    ) u_drv (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .sel    (sel),
        .lane   (lane),
        .row    (addr[ROW_LO +: MA_W]),
        .col    (addr[COL_LO +: MA_W]),
        .ph     (ph),
        .col_ph (col_ph),
        .cs_n   (cs_n),
        .wru_n  (wru_n),
        .wrl_n  (wrl_n),
        .ma     (ma),
        .ras_n  (ras_n),
        .cas_n  (cas_n),
        .dwe_n  (dwe_n),
        .dcs_n  (dcs_n),
        .dtack_n(dtack_n),
        .stall  (stall)
    );

endmodule

// File: rtl/wr_pace_chk.sv
module wr_pace_chk #(
    parameter int NREG    = 4,
    parameter int MA_W    = 11,
    parameter int MIN_LEN = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            as_n,
    input logic [NREG-1:0] cs_n,
    input logic            wru_n,
    input logic            wrl_n,
    input logic [MA_W-1:0] ma,
    input logic            ras_n,
    input logic            cas_n,
    input logic            dtack_n,
    input logic            stall
);

    logic [7:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_cnt <= '0;
        end else if (stall) begin
            busy_cnt <= (busy_cnt == 8'hFF) ? busy_cnt : busy_cnt + 8'd1;
        end else begin
            busy_cnt <= '0;
        end
    end

    assert_one_target_R3: assert property (@(posedge clk) disable iff (rst)
        $countones({~cs_n, ~ras_n}) <= 1);

    assert_we_in_access_R4: assert property (@(posedge clk) disable iff (rst)
        (!wru_n || !wrl_n) |-> stall);

    assert_cas_after_ras_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(cas_n) |-> (!ras_n && $past(!ras_n)));

    assert_col_stable_R5: assert property (@(posedge clk) disable iff (rst)
        (!cas_n && $past(!cas_n)) |-> $stable(ma));

    assert_min_length_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(dtack_n) |-> (busy_cnt >= 8'(MIN_LEN - 1)));

    assert_release_R8: assert property (@(posedge clk) disable iff (rst)
        (!dtack_n && as_n) |=> (dtack_n && !stall && (&cs_n) && ras_n));

    assert_ack_inside_R9: assert property (@(posedge clk) disable iff (rst)
        !dtack_n |-> stall);

endmodule

bind wr_pace_ctrl wr_pace_chk #(
    .NREG   (NREG),
    .MA_W   (MA_W),
    .MIN_LEN(MIN_LEN)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .as_n   (as_n),
    .cs_n   (cs_n),
    .wru_n  (wru_n),
    .wrl_n  (wrl_n),
    .ma     (ma),
    .ras_n  (ras_n),
    .cas_n  (cas_n),
    .dtack_n(dtack_n),
    .stall  (stall)
);

// File: tb/sim_wr_pace_ctrl.sv
`timescale 1ns/1ps
module sim_wr_pace_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        as_n = 1'b0;
    logic        rw_n = 1'b0;
    logic        uds_n = 1'b0;
    logic        lds_n = 1'b0;
    logic [2:0]  fc = 3'd5;
    logic [23:0] addr = 24'h000010;
    logic [15:0] ws_cs = {4'd1, 4'd15, 4'd5, 4'd0};
    logic [3:0]  ws_dram = 4'd3;
    logic [3:0]  cs_n;
    logic        wru_n, wrl_n, ras_n, cas_n, dwe_n, dtack_n, stall;
    logic [10:0] ma;
    logic [1:0]  dcs_n;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;
    string cur_tag = "R1";

    always #10 clk = ~clk;

    wr_pace_ctrl u0 (
        .clk(clk), .rst(rst), .as_n(as_n), .rw_n(rw_n), .uds_n(uds_n),
        .lds_n(lds_n), .fc(fc), .addr(addr), .ws_cs(ws_cs), .ws_dram(ws_dram),
        .cs_n(cs_n), .wru_n(wru_n), .wrl_n(wrl_n), .ma(ma), .ras_n(ras_n),
        .cas_n(cas_n), .dwe_n(dwe_n), .dcs_n(dcs_n), .dtack_n(dtack_n),
        .stall(stall)
    );

    // reference model: kind 0 none, 1 chip-select, 2 DRAM; phase -1 = idle
    int          m_phase = -1;
    int          m_len = 0;
    int          m_kind = 0;
    int          m_idx = 0;
    bit          m_armed = 0;
    logic        m_up = 1'b1;
    logic        m_lo = 1'b1;
    logic [23:0] m_addr = '0;

    function automatic void mdec(input logic [23:0] a, output int k,
                                 output int ix, output int w);
        k = 0; ix = 0; w = 6;
        if (a[23:20] == 4'h0)      begin k = 1; ix = 0; w = int'(ws_cs[3:0]); end
        else if (a[23:20] == 4'h1) begin k = 1; ix = 1; w = int'(ws_cs[7:4]); end
        else if (a[23:16] == 8'h20) begin k = 1; ix = 2; w = int'(ws_cs[11:8]); end
        else if (a[23:16] == 8'h21) begin k = 1; ix = 3; w = int'(ws_cs[15:12]); end
        else if (a[23])            begin k = 2; w = int'(ws_dram); end
    endfunction

    always @(posedge clk) begin
        int k, ix, w;
        cycles++;
        if (rst) begin
            m_phase = -1;
            m_armed = 0;
        end else if (m_phase < 0) begin
            if (!as_n && !rw_n && fc != 3'b111 && m_armed) begin
                mdec(addr, k, ix, w);
                m_kind = k; m_idx = ix;
                m_len = (w + 2 > 4) ? w + 2 : 4;
                m_up = uds_n; m_lo = lds_n; m_addr = addr;
                m_phase = 0;
                m_armed = 0;
            end else if (as_n) begin
                m_armed = 1;
            end
        end else begin
            if (as_n) begin
                m_phase = -1;
                m_armed = 1;
            end else if (m_phase < m_len - 1) begin
                m_phase++;
            end
        end
    end

    task automatic cmp(input string sig, input string rq,
                       input logic [31:0] act, input logic [31:0] exp);
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s (scenario %s) act=%h exp=%h at %0t",
                     rq, sig, cur_tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        bit busy, col, isc, isd;
        logic [3:0]  e_cs;
        logic [10:0] e_ma;
        busy = (m_phase >= 0);
        col  = (m_phase >= 1);
        isc  = busy && m_kind == 1;
        isd  = busy && m_kind == 2;
        e_cs = 4'hF;
        if (isc) e_cs[m_idx] = 1'b0;
        e_ma = isd ? (col ? m_addr[11:1] : m_addr[22:12]) : 11'd0;
        vectors++;
        cmp("cs_n",    "R4", 32'(cs_n),    32'(e_cs));
        cmp("wru_n",   "R4", 32'(wru_n),   32'(isc ? m_up : 1'b1));
        cmp("wrl_n",   "R4", 32'(wrl_n),   32'(isc ? m_lo : 1'b1));
        cmp("ma",      "R5", 32'(ma),      32'(e_ma));
        cmp("ras_n",   "R5", 32'(ras_n),   32'(!isd));
        cmp("cas_n",   "R5", 32'(cas_n),   32'(!(isd && col)));
        cmp("dwe_n",   "R5", 32'(dwe_n),   32'(!(isd && col)));
        cmp("dcs_n",   "R5", 32'(dcs_n),   32'(isd ? {m_up, m_lo} : 2'b11));
        cmp("dtack_n", "R6", 32'(dtack_n), 32'(!(busy && m_phase == m_len - 1)));
        cmp("stall",   "R9", 32'(stall),   32'(busy));
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cycles > 20000) begin
            miscompares++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    // starts a write and keeps as_n low `extra` clocks past the acknowledge
    task automatic bus_write(input logic [23:0] a, input logic u, input logic l,
                             input int extra, input string tag);
        int n;
        @(negedge clk);
        cur_tag = tag;
        addr = a; uds_n = u; lds_n = l; rw_n = 1'b0; fc = 3'd5; as_n = 1'b0;
        n = 0;
        while (dtack_n && n < 40) begin
            @(negedge clk);
            n++;
        end
        repeat (extra) @(negedge clk);
        as_n = 1'b1; uds_n = 1'b1; lds_n = 1'b1; rw_n = 1'b1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // R2: strobe already low out of reset, never seen high -> no start
        repeat (3) @(negedge clk);
        vectors++;
        if (!(cs_n == 4'hF && wru_n && wrl_n && ras_n && cas_n && dwe_n &&
              dcs_n == 2'b11 && dtack_n && !stall && ma == 11'd0)) begin
            miscompares++;
            $display("FAIL R1 reset state act=%h/%b exp=F/idle", cs_n, stall);
        end
        rst = 1'b0;
        cur_tag = "R2";
        idle(5);
        as_n = 1'b1;
        @(negedge clk);
        as_n = 1'b0;                       // now armed: starts on next edge
        while (dtack_n) @(negedge clk);
        as_n = 1'b1; rw_n = 1'b1;
        idle(2);

        bus_write(24'h000100, 1'b0, 1'b0, 0, "R4");   // word, L=4
        idle(1);
        bus_write(24'h100200, 1'b0, 1'b1, 0, "R4");   // even byte, L=7
        bus_write(24'h100201, 1'b1, 1'b0, 1, "R4");   // odd byte, one-clock gap
        idle(1);
        bus_write(24'h20ABCE, 1'b0, 1'b0, 0, "R6");   // ws 15, L=17
        idle(1);
        bus_write(24'h213456, 1'b0, 1'b0, 0, "R3");   // ws 1 -> floor of 4
        idle(1);
        bus_write(24'hD5A5A4, 1'b0, 1'b0, 0, "R5");   // DRAM word, L=5
        idle(1);
        ws_dram = 4'd0;
        idle(1);
        bus_write(24'h9FFFFF, 1'b1, 1'b0, 0, "R5");   // DRAM odd byte, L=4
        idle(1);
        bus_write(24'h400000, 1'b0, 1'b0, 0, "R7");   // unmapped, L=8
        idle(1);
        bus_write(24'h0000A0, 1'b0, 1'b0, 4, "R8");   // strobe held past ack
        idle(1);

        // R2: a read and a non-memory function code start nothing
        cur_tag = "R2";
        rw_n = 1'b1; fc = 3'd5; addr = 24'h000040; uds_n = 1'b0; as_n = 1'b0;
        idle(6);
        as_n = 1'b1; idle(1);
        rw_n = 1'b0; fc = 3'b111; as_n = 1'b0;
        idle(6);
        as_n = 1'b1; fc = 3'd5; uds_n = 1'b1;
        idle(2);

        // R10: strobe released two clocks into a long access
        cur_tag = "R10";
        addr = 24'h200010; rw_n = 1'b0; uds_n = 1'b0; lds_n = 1'b0; as_n = 1'b0;
        idle(3);
        as_n = 1'b1; uds_n = 1'b1; lds_n = 1'b1; rw_n = 1'b1;
        idle(3);

        bus_write(24'h880002, 1'b0, 1'b1, 2, "R8");   // DRAM hold after ack
        idle(4);
        finish_run();
    end

endmodule